// File: doc/BRIEF.md
# UART Register Front-End

This block is the software-facing side of a serial port. A processor reaches it through a plain 32-bit strobe bus with four word registers. Bytes written to the transmit register go into a transmit byte queue, which a serial shifter drains through a valid/ready stream. Bytes produced by the serial receiver enter a receive byte queue, which software drains by reading the receive register. A status word reports how full each queue is, whether the interrupt is enabled, and three sticky line-error flags. A control word can empty either queue and can turn the interrupt on or off.

The receive input has no back-pressure, because a serial receiver cannot pause the line. A byte that arrives while the receive queue is full is lost and is recorded as an overrun. The transmit output is a normal valid/ready stream. `tx_valid` stays high for as long as the queue holds a byte, `tx_data` shows the oldest byte, and that byte leaves on any clock edge where `tx_valid` and `tx_ready` are both high. The consumer may hold `tx_ready` low for any number of cycles.

One interrupt line serves both directions. It pulses for one cycle when the transmit queue drains to empty. It also stays high for as long as received data is waiting. Both sources count only while the interrupt is enabled.

Top module: `uart_reg_front`

## Requirements
- R1: Address bits 3:2 select the register: 0 receive data, 1 transmit data, 2 status, 3 control. A read of the transmit or control register returns zero. A write to the receive or status register changes nothing.
- R2: A status read returns bit 0 receive data waiting, bit 1 receive queue full, bit 2 transmit queue empty, bit 3 transmit queue full, bit 4 interrupt enabled, bit 5 overrun, bit 6 frame error and bit 7 parity error. Bits 31:8 read as zero.
- R3: A receive read returns the oldest received byte in bits 7:0, with zeros above, and removes that byte at the clock edge. A read while the queue is empty returns zero and removes nothing.
- R4: A transmit write appends bits 7:0 of the write data when the queue (FIFO_DEPTH entries, default 16) has room. A write while the queue is full is dropped.
- R5: `tx_valid` is high exactly while the transmit queue is non-empty. `tx_data` is the oldest byte. The byte is removed on an edge with `tx_ready` high, and bytes leave in the order they were written.
- R6: `rx_valid` appends `rx_data` when the receive queue has room. When the queue is full at that edge, the byte is dropped and the overrun flag (status bit 5) is set.
- R7: A one-cycle `rx_frame_err` or `rx_parity_err` strobe sets status bit 6 or 7. Bits 7:5 stay set until a status read clears them at that read's edge. A set in the same cycle as the read wins.
- R8: A control write with bit 0 set empties the transmit queue, and one with bit 1 set empties the receive queue. A flush wins over a push or pop in the same cycle. Bit 4 of every control write becomes the interrupt enable. The flush bits are not stored.
- R9: `irq` is high when the enable is set and either receive data is waiting, or the transmit queue became empty in this cycle after being non-empty in the previous one. That transmit event lasts one cycle.
- R10: After reset both queues are empty, the interrupt is disabled, all error flags are clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the strobe cycle; zero when not reading |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue non-empty |
| tx_ready | input | 1 | Shifter accepts tx_data at this edge |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present (no back-pressure) |
| rx_frame_err | input | 1 | One-cycle frame error strobe |
| rx_parity_err | input | 1 | One-cycle parity error strobe |
| irq | output | 1 | Shared interrupt |

## Verification
Read data is combinational and belongs to the cycle of the strobe. Every side effect of an access takes hold at the edge that ends that cycle: a pop, a push, a flush, a flag clear or a change of enable. So a written byte shows on `tx_valid` one cycle later, and a status read sees the effect of an earlier access one cycle after it. The transmit-empty pulse appears in the cycle right after the edge that removes the last byte, and lasts for that one cycle. The bench keeps a behavioural model with queues and updates it at each rising edge. It samples and compares outputs one time unit after the falling edge, so every comparison sees the state left by the previous edge combined with the inputs of the current cycle.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  typedef enum logic [1:0] {
    SEL_RXD  = 2'd0,
    SEL_TXD  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int unsigned ST_RXV = 0;
  localparam int unsigned ST_RXF = 1;
  localparam int unsigned ST_TXE = 2;
  localparam int unsigned ST_TXF = 3;
  localparam int unsigned ST_IE  = 4;
  localparam int unsigned ST_ERR_LO = 5;
  localparam int unsigned STAT_W = 8;

  localparam int unsigned CT_FLUSH_TX = 0;
  localparam int unsigned CT_FLUSH_RX = 1;
  localparam int unsigned CT_IE       = 4;

  localparam int unsigned ERR_N   = 3;
  localparam int unsigned ERR_OVR = 0;
  localparam int unsigned ERR_FRM = 1;
  localparam int unsigned ERR_PAR = 2;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assert_full_push_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  assert_pop_frees_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop && !flush) |=> !full);
endmodule

// File: rtl/uart_err_sticky.sv
module uart_err_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]);
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ie,
  input  logic tx_empty,
  input  logic rx_avail,
  output logic tx_edge,
  output logic irq
);
  logic prev_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_empty <= 1'b1;
    else        prev_empty <= tx_empty;
  end

  assign tx_edge = ie && tx_empty && !prev_empty;
  assign irq     = tx_edge || (ie && rx_avail);

  assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_edge |=> !tx_edge);
  assert_edge_on_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && $rose(tx_empty)) |-> irq);
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front #(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  output logic              irq
);
  import uart_regs_pkg::*;

  reg_sel_e rsel;
  logic rd, wr, ctrl_wr, stat_rd;
  logic flush_tx, flush_rx;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0] rx_head;
  logic ie;
  logic [ERR_N-1:0] err_set, err_flags;
  logic [STAT_W-1:0] status;
  logic tx_edge;

  assign rsel     = reg_sel_e'(bus_addr[3:2]);
  assign rd       = bus_sel && !bus_wr;
  assign wr       = bus_sel && bus_wr;
  assign ctrl_wr  = wr && (rsel == SEL_CTRL);
  assign stat_rd  = rd && (rsel == SEL_STAT);
  assign flush_tx = ctrl_wr && bus_wdata[CT_FLUSH_TX];
  assign flush_rx = ctrl_wr && bus_wdata[CT_FLUSH_RX];

  uart_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_tx),
    .push(wr && (rsel == SEL_TXD)), .push_data(bus_wdata[7:0]),
    .pop(tx_ready), .head(tx_data), .empty(tx_empty), .full(tx_full)
  );

  uart_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_rx),
    .push(rx_valid), .push_data(rx_data),
    .pop(rd && (rsel == SEL_RXD)), .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  assign tx_valid = !tx_empty;

  always_comb begin
    err_set = '0;
    err_set[ERR_OVR] = rx_valid && rx_full;
    err_set[ERR_FRM] = rx_frame_err;
    err_set[ERR_PAR] = rx_parity_err;
  end

  uart_err_sticky #(.N(ERR_N)) u_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(stat_rd), .flags(err_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ie <= 1'b0;
    else if (ctrl_wr) ie <= bus_wdata[CT_IE];
  end

  always_comb begin
    status = '0;
    status[ST_RXV] = !rx_empty;
    status[ST_RXF] = rx_full;
    status[ST_TXE] = tx_empty;
    status[ST_TXF] = tx_full;
    status[ST_IE]  = ie;
    status[ST_ERR_LO +: ERR_N] = err_flags;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (rsel)
        SEL_RXD:  bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
        SEL_STAT: bus_rdata[STAT_W-1:0] = status;
        default:  bus_rdata = '0;
      endcase
    end
  end

  uart_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .ie(ie), .tx_empty(tx_empty),
    .rx_avail(!rx_empty), .tx_edge(tx_edge), .irq(irq)
  );

  assert_ie_follows_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ie == $past(bus_wdata[CT_IE])));
  assert_ie_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ie));
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);
  assert_tx_valid_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (rsel == SEL_TXD) && !flush_tx) |=> tx_valid);
endmodule

// File: tb/uart_reg_front_tb.sv
module uart_reg_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, rx_frame_err = 1'b0, rx_parity_err = 1'b0;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_reg_front #(.FIFO_DEPTH(D), .ADDR_W(4), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .irq(irq)
  );

  int n_vec = 0, n_bad = 0;
  string phase = "R10 reset";
  bit done = 0;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit m_ie = 0, m_ovr = 0, m_fe = 0, m_pe = 0, m_prev_empty = 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s]: actual %h expected %h at %0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] st;
    bit exp_irq;
    st = {m_pe, m_fe, m_ovr, m_ie, txq.size() == D, txq.size() == 0,
          rxq.size() == D, rxq.size() > 0};
    exp_irq = m_ie && ((txq.size() == 0 && !m_prev_empty) || rxq.size() > 0);
    check("R9 irq", {31'd0, irq}, {31'd0, exp_irq});
    check("R5 tx_valid", {31'd0, tx_valid}, {31'd0, txq.size() > 0});
    if (txq.size() > 0) check("R5 tx_data", {24'd0, tx_data}, {24'd0, txq[0]});
    if (bus_sel && !bus_wr) begin
      case (bus_addr[3:2])
        2'd0: check("R3 rx read", bus_rdata, (rxq.size() > 0) ? {24'd0, rxq[0]} : 32'd0);
        2'd2: begin
          check("R2 status low", {28'd0, bus_rdata[3:0]}, {28'd0, st[3:0]});
          check("R8 status ie", {31'd0, bus_rdata[4]}, {31'd0, st[4]});
          check("R6 overrun", {31'd0, bus_rdata[5]}, {31'd0, st[5]});
          check("R7 frame/parity", {30'd0, bus_rdata[7:6]}, {30'd0, st[7:6]});
          check("R2 upper zero", {8'd0, bus_rdata[31:8]}, 32'd0);
        end
        default: check("R1 write-only reads zero", bus_rdata, 32'd0);
      endcase
    end else begin
      check("R1 idle rdata", bus_rdata, 32'd0);
    end
  endtask

  task automatic update();
    int txn = txq.size();
    int rxn = rxq.size();
    bit w = bus_sel && bus_wr;
    bit r = bus_sel && !bus_wr;
    logic [1:0] a = bus_addr[3:2];
    bit ftx = w && a == 2'd3 && bus_wdata[0];
    bit frx = w && a == 2'd3 && bus_wdata[1];
    bit ovr_set = rx_valid && rxn == D;
    m_prev_empty = (txn == 0);
    if (ftx) txq.delete();
    else begin
      if (txn > 0 && tx_ready) void'(txq.pop_front());
      if (w && a == 2'd1 && txn < D) txq.push_back(bus_wdata[7:0]);
    end
    if (frx) rxq.delete();
    else begin
      if (r && a == 2'd0 && rxn > 0) void'(rxq.pop_front());
      if (rx_valid && rxn < D) rxq.push_back(rx_data);
    end
    if (r && a == 2'd2) begin m_ovr = 0; m_fe = 0; m_pe = 0; end
    if (ovr_set) m_ovr = 1;
    if (rx_frame_err) m_fe = 1;
    if (rx_parity_err) m_pe = 1;
    if (w && a == 2'd3) m_ie = bus_wdata[4];
  endtask

  task automatic step();
    #1;
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 0; rx_frame_err = 0; rx_parity_err = 0;
  endtask

  task automatic bus(bit is_wr, logic [3:0] addr, logic [31:0] data);
    bus_sel = 1; bus_wr = is_wr; bus_addr = addr; bus_wdata = data;
    step();
  endtask

  task automatic rx_in(logic [7:0] b);
    rx_valid = 1; rx_data = b;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    phase = "R10 reset";
    bus(0, 4'h8, 0);
    bus(0, 4'h4, 0);
    bus(0, 4'hC, 0);
    bus(0, 4'h0, 0);

    phase = "R1 ignored writes";
    bus(1, 4'h0, 32'hFF);
    bus(1, 4'h8, 32'hFF);
    bus(0, 4'h8, 0);

    phase = "R9 tx drain edge";
    bus(1, 4'hC, 32'h10);
    bus(1, 4'h4, 32'hA1);
    bus(1, 4'h4, 32'hFFFF_FFB2);
    bus(1, 4'h5, 32'hC3);
    bus(0, 4'h8, 0);
    tx_ready = 1;
    idle(5);
    tx_ready = 0;

    phase = "R4 tx overfill";
    for (int i = 0; i < D + 2; i++) bus(1, 4'h4, 32'(8'h40 + i));
    bus(0, 4'h8, 0);
    phase = "R5 tx order";
    tx_ready = 1;
    idle(D + 3);
    tx_ready = 0;

    phase = "R3 rx read";
    rx_in(8'h11); rx_in(8'h22); rx_in(8'h33);
    bus(0, 4'h8, 0);
    bus(0, 4'h0, 0); bus(0, 4'h0, 0); bus(0, 4'h0, 0);
    bus(0, 4'h0, 0);

    phase = "R6 overrun";
    for (int i = 0; i < D + 2; i++) rx_in(8'h80 + 8'(i));
    bus(0, 4'h8, 0);
    bus(0, 4'h8, 0);
    for (int i = 0; i < D + 1; i++) bus(0, 4'h0, 0);

    phase = "R7 sticky errors";
    rx_frame_err = 1; step();
    rx_parity_err = 1; step();
    bus(0, 4'h8, 0);
    bus(0, 4'h8, 0);
    rx_frame_err = 1; bus(0, 4'h8, 0);
    bus(0, 4'h8, 0);
    bus(0, 4'h8, 0);

    phase = "R8 flush";
    bus(1, 4'h4, 32'h55); bus(1, 4'h4, 32'h66);
    rx_in(8'h77); rx_in(8'h78);
    bus(0, 4'h8, 0);
    rx_valid = 1; rx_data = 8'h99;
    bus(1, 4'hC, 32'h13);
    bus(0, 4'h8, 0);
    bus(1, 4'h4, 32'h5A);
    bus(1, 4'hC, 32'h01);
    bus(0, 4'h8, 0);

    phase = "R9 disabled";
    bus(1, 4'h4, 32'h01);
    rx_in(8'h01);
    tx_ready = 1; idle(3); tx_ready = 0;
    bus(0, 4'h0, 0);

    phase = "R5 random mix";
    bus(1, 4'hC, 32'h10);
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      tx_ready = $urandom_range(0, 1);
      rx_valid = ($urandom_range(0, 3) == 0);
      rx_data = 8'($urandom);
      rx_frame_err = ($urandom_range(0, 15) == 0);
      rx_parity_err = ($urandom_range(0, 15) == 0);
      case (op)
        0, 1, 2: begin bus_sel = 1; bus_wr = 1; bus_addr = 4'h4; bus_wdata = $urandom; end
        3, 4:    begin bus_sel = 1; bus_wr = 0; bus_addr = 4'h0; end
        5:       begin bus_sel = 1; bus_wr = 0; bus_addr = 4'h8; end
        6:       begin bus_sel = 1; bus_wr = 1; bus_addr = 4'hC;
                       bus_wdata = ($urandom_range(0, 7) == 0) ? 32'h13 : 32'h10; end
        default: ;
      endcase
      step();
    end
    tx_ready = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule